// File: doc/BRIEF.md
# Pixel to Bus Cycle Packer

This block sits between a pixel source and the strobe timing engine of a parallel display bus. It takes one pixel at a time over a valid/ready handshake and splits it into one, two or three bus words of the selected bus width. It emits those words over a second valid/ready handshake, most significant bits first. A fourth format packs two pixels into three bus words, with the middle word shared between the two pixels.

Software or a sequencer first presents the pixel depth, the bus width, the cycle format and the total pixel count of the frame (width times height), then pulses start. The block checks the combination. A legal one turns the block busy and latches the setup. An illegal one raises an error flag and starts nothing. When the last bus word of the last pixel has been taken downstream, the block pulses frame-done and drops busy by itself.

Top module: `pixel_bus_packer`

## Requirements
- R1: Depth codes 0..3 mean 12, 16, 18, 24 bits; bus codes 0..3 mean 8, 9, 12, 16 lines; format codes 0..3 mean one word per pixel (depth equals lines), two words per pixel (depth is twice lines), three words per pixel (depth is three times lines), three words per two pixels (twice depth is three times lines). A start with a matching format, a nonzero count and busy low sets busy on the next cycle.
- R2: A start whose depth and bus width fit no format, whose format code differs from the one the ratio gives, whose count is zero, or whose count is odd in the three-per-two format sets the error flag, leaves busy low and accepts no pixel. A later accepted start clears the flag.
- R3: Pixel bits above the selected depth are ignored. Every bus word carries its payload in its low bits, with the unused upper lines driven to zero. In the one-word format the word is the whole pixel.
- R4: In the two-word format the upper half of the pixel goes first and the lower half second.
- R5: In the three-word format (24 bits on 8 lines) the words are bits 23:16, then 15:8, then 7:0.
- R6: In the three-per-two format, word 1 is the top full bus width of the first pixel. Word 2 holds the last half bus of the first pixel in its upper half and the first half bus of the second pixel in its lower half. Word 3 is the remaining full bus width of the second pixel.
- R7: Pixel ready is never high while a bus word of the current pixel or pair is pending. A pending bus word and its valid are held unchanged while bus ready is low.
- R8: Once the last bus word of the programmed count is accepted, frame-done is high for exactly one cycle, busy is low from that cycle on, and no further pixel is accepted.
- R9: A start pulse while busy is ignored: the latched setup, the count, the words produced and the error flag are unchanged.
- R10: After reset, busy, error, frame-done, bus valid and pixel ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, takes the setup below |
| depth_i | input | 2 | Pixel depth code |
| lines_i | input | 2 | Bus width code |
| fmt_i | input | 2 | Cycle format code |
| pix_total_i | input | CNT_W | Pixels in the frame |
| pix_valid_i | input | 1 | Pixel present |
| pix_ready_o | output | 1 | Pixel accepted this cycle when valid |
| pix_data_i | input | PIX_W | Pixel, right aligned |
| bus_valid_o | output | 1 | Bus word present |
| bus_ready_i | input | 1 | Timing engine takes the word |
| bus_data_o | output | BUS_W | Bus word, right aligned |
| busy_o | output | 1 | Frame in progress (enable) |
| cfg_err_o | output | 1 | Last start was refused |
| frame_done_o | output | 1 | One-cycle end of frame pulse |

## Verification
The bench runs every legal depth and bus pairing and compares each emitted word with slices it works out from the pixel values. A packer that swapped word order, leaked bits above the depth or shifted the split in the shared middle word of a pair would show a wrong word. Downstream stalls are applied in the pair format: a design that advanced its shifter without a handshake would lose a word, and one that took a new pixel early would be caught by the ready/valid overlap check. The refused setups, odd counts in pair mode and a start pulse in mid frame are each driven to show the error flag, the busy state and the word stream react exactly as the rules say. A counter that finished one pixel early or late would miscount the words or place frame-done wrongly.

// File: rtl/pxpk_pkg.sv
package pxpk_pkg;

  typedef enum logic [1:0] {
    FMT_ONE   = 2'd0,
    FMT_TWO   = 2'd1,
    FMT_THREE = 2'd2,
    FMT_PAIR  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [5:0] dbits;
    logic [5:0] lbits;
    logic [1:0] cycles;
    logic       pair;
  } pxpk_cfg_t;

  // depth code to bit count (needs PIX_W >= 24)
  function automatic logic [5:0] depth_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd12;
      2'd1:    return 6'd16;
      2'd2:    return 6'd18;
      default: return 6'd24;
    endcase
  endfunction

  // bus code to line count (needs BUS_W >= 16)
  function automatic logic [5:0] lines_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd8;
      2'd1:    return 6'd9;
      2'd2:    return 6'd12;
      default: return 6'd16;
    endcase
  endfunction

endpackage

// File: rtl/pxpk_decode.sv
module pxpk_decode
  import pxpk_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic [1:0]       depth_code,
  input  logic [1:0]       lines_code,
  input  logic [1:0]       fmt_code,
  input  logic [CNT_W-1:0] total,
  output pxpk_cfg_t        cfg,
  output logic             ok
);

  logic [6:0] d7, l7;
  fmt_e       derived;
  logic       fits;

  always_comb begin
    d7      = {1'b0, depth_bits(depth_code)};
    l7      = {1'b0, lines_bits(lines_code)};
    fits    = 1'b1;
    derived = FMT_ONE;
    if (d7 == l7)                 derived = FMT_ONE;
    else if (d7 == (l7 << 1))     derived = FMT_TWO;
    else if (d7 == l7 * 7'd3)     derived = FMT_THREE;
    else if ((d7 << 1) == l7 * 7'd3) derived = FMT_PAIR;
    else                          fits = 1'b0;

    cfg.dbits  = d7[5:0];
    cfg.lbits  = l7[5:0];
    cfg.pair   = (derived == FMT_PAIR);
    case (derived)
      FMT_ONE: cfg.cycles = 2'd1;
      FMT_TWO: cfg.cycles = 2'd2;
      default: cfg.cycles = 2'd3;
    endcase

    ok = fits && (fmt_e'(fmt_code) == derived) && (total != '0)
         && !(cfg.pair && total[0]);
  end

endmodule

// File: rtl/pxpk_gather.sv
module pxpk_gather #(
  parameter int PIX_W = 24,
  parameter int CNT_W = 20,
  localparam int GRP_W = 2 * PIX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic             active_i,
  input  logic             ser_empty_i,
  input  logic [5:0]       dbits_i,
  input  logic             pair_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             pix_ready_o,
  output logic             grp_vld_o,
  output logic [GRP_W-1:0] grp_bits_o,
  output logic             rem_zero_o
);

  logic [CNT_W-1:0] rem_q;
  logic             have_a_q;
  logic [PIX_W-1:0] a_q;
  logic [PIX_W-1:0] dmask, cur_m;
  logic             fire;

  assign dmask       = ~({PIX_W{1'b1}} << dbits_i);
  assign cur_m       = pix_data_i & dmask;
  assign rem_zero_o  = (rem_q == '0);
  assign pix_ready_o = active_i && ser_empty_i && !rem_zero_o;
  assign fire        = pix_valid_i && pix_ready_o;
  assign grp_vld_o   = fire && (!pair_i || have_a_q);

  always_comb begin
    if (pair_i)
      grp_bits_o = (({{PIX_W{1'b0}}, a_q} << dbits_i) | {{PIX_W{1'b0}}, cur_m})
                   << (GRP_W - 2 * int'(dbits_i));
    else
      grp_bits_o = {{PIX_W{1'b0}}, cur_m} << (GRP_W - int'(dbits_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q    <= '0;
      have_a_q <= 1'b0;
      a_q      <= '0;
    end else if (load_i) begin
      rem_q    <= total_i;
      have_a_q <= 1'b0;
    end else if (fire) begin
      rem_q <= rem_q - 1'b1;
      if (pair_i && !have_a_q) begin
        a_q      <= cur_m;
        have_a_q <= 1'b1;
      end else begin
        have_a_q <= 1'b0;
      end
    end
  end

  // R6
  pair_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (have_a_q && active_i) |-> pair_i);

endmodule

// File: rtl/pxpk_serializer.sv
module pxpk_serializer #(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16,
  localparam int GRP_W = 2 * PIX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic [1:0]       cycles_i,
  input  logic [5:0]       lbits_i,
  input  logic             bus_ready_i,
  output logic             bus_valid_o,
  output logic [BUS_W-1:0] bus_data_o,
  output logic             empty_o,
  output logic             last_fire_o
);

  logic [GRP_W-1:0] sreg_q, sreg_n;
  logic [1:0]       left_q, left_n;
  logic [BUS_W-1:0] word_q;

  function automatic logic [BUS_W-1:0] top_word(input logic [GRP_W-1:0] s,
                                                input logic [5:0] l);
    return s[GRP_W-1 -: BUS_W] >> (BUS_W - int'(l));
  endfunction

  assign bus_valid_o = (left_q != 2'd0);
  assign empty_o     = !bus_valid_o;
  assign bus_data_o  = word_q;
  assign last_fire_o = bus_valid_o && bus_ready_i && (left_q == 2'd1);

  always_comb begin
    sreg_n = sreg_q;
    left_n = left_q;
    if (load_i) begin
      sreg_n = grp_i;
      left_n = cycles_i;
    end else if (bus_valid_o && bus_ready_i) begin
      sreg_n = sreg_q << lbits_i;
      left_n = left_q - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      left_q <= 2'd0;
      word_q <= '0;
    end else begin
      sreg_q <= sreg_n;
      left_q <= left_n;
      word_q <= top_word(sreg_n, lbits_i);
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_data_o)));

  // R7
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !bus_valid_o);

endmodule

// File: rtl/pixel_bus_packer.sv
module pixel_bus_packer
  import pxpk_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16,
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       depth_i,
  input  logic [1:0]       lines_i,
  input  logic [1:0]       fmt_i,
  input  logic [CNT_W-1:0] pix_total_i,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             bus_valid_o,
  input  logic             bus_ready_i,
  output logic [BUS_W-1:0] bus_data_o,
  output logic             busy_o,
  output logic             cfg_err_o,
  output logic             frame_done_o
);

  localparam int GRP_W = 2 * PIX_W;

  pxpk_cfg_t        dec_cfg, cfg_q;
  logic             dec_ok;
  logic             busy_q, err_q, done_q;
  logic             start_take, load;
  logic             ser_empty, last_fire, rem_zero;
  logic             grp_vld;
  logic [GRP_W-1:0] grp_bits;

  assign start_take   = start_i && !busy_q;
  assign load         = start_take && dec_ok;
  assign busy_o       = busy_q;
  assign cfg_err_o    = err_q;
  assign frame_done_o = done_q;

  pxpk_decode #(.CNT_W(CNT_W)) u_decode (
    .depth_code (depth_i),
    .lines_code (lines_i),
    .fmt_code   (fmt_i),
    .total      (pix_total_i),
    .cfg        (dec_cfg),
    .ok         (dec_ok)
  );

  pxpk_gather #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_gather (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load),
    .total_i     (pix_total_i),
    .active_i    (busy_q),
    .ser_empty_i (ser_empty),
    .dbits_i     (cfg_q.dbits),
    .pair_i      (cfg_q.pair),
    .pix_valid_i (pix_valid_i),
    .pix_data_i  (pix_data_i),
    .pix_ready_o (pix_ready_o),
    .grp_vld_o   (grp_vld),
    .grp_bits_o  (grp_bits),
    .rem_zero_o  (rem_zero)
  );

  pxpk_serializer #(.PIX_W(PIX_W), .BUS_W(BUS_W)) u_ser (
    .clk         (clk),
    .rst         (rst),
    .load_i      (grp_vld),
    .grp_i       (grp_bits),
    .cycles_i    (cfg_q.cycles),
    .lbits_i     (cfg_q.lbits),
    .bus_ready_i (bus_ready_i),
    .bus_valid_o (bus_valid_o),
    .bus_data_o  (bus_data_o),
    .empty_o     (ser_empty),
    .last_fire_o (last_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_take) begin
        if (dec_ok) begin
          busy_q <= 1'b1;
          err_q  <= 1'b0;
          cfg_q  <= dec_cfg;
        end else begin
          err_q <= 1'b1;
        end
      end else if (busy_q && last_fire && rem_zero) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // R2
  reject_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !dec_ok) |=> (!busy_o && cfg_err_o));

  // R7
  gap_chk: assert property (@(posedge clk) disable iff (rst)
    pix_ready_o |-> !bus_valid_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |=> !frame_done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |-> (!busy_o && !pix_ready_o));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o) |=> ($stable(cfg_q) && $stable(cfg_err_o)));

endmodule

// File: tb/pixel_bus_packer_tb_top.sv
module pixel_bus_packer_tb_top;

  localparam int PIX_W = 24;
  localparam int BUS_W = 16;
  localparam int CNT_W = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [1:0]       depth_i = '0, lines_i = '0, fmt_i = '0;
  logic [CNT_W-1:0] pix_total_i = '0;
  logic             pix_valid_i = 1'b0;
  logic             pix_ready_o;
  logic [PIX_W-1:0] pix_data_i = '0;
  logic             bus_valid_o;
  logic             bus_ready_i = 1'b0;
  logic [BUS_W-1:0] bus_data_o;
  logic             busy_o, cfg_err_o, frame_done_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  int dtab [4] = '{12, 16, 18, 24};
  int ltab [4] = '{8, 9, 12, 16};

  logic [23:0] pix_mem [16];
  int          exp_mem [48];
  int          got_mem [64];

  always #10 clk = ~clk;

  pixel_bus_packer #(.PIX_W(PIX_W), .BUS_W(BUS_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .depth_i(depth_i),
    .lines_i(lines_i), .fmt_i(fmt_i), .pix_total_i(pix_total_i),
    .pix_valid_i(pix_valid_i), .pix_ready_o(pix_ready_o),
    .pix_data_i(pix_data_i), .bus_valid_o(bus_valid_o),
    .bus_ready_i(bus_ready_i), .bus_data_o(bus_data_o), .busy_o(busy_o),
    .cfg_err_o(cfg_err_o), .frame_done_o(frame_done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic int mk(input int w);
    return (1 << w) - 1;
  endfunction

  function automatic int build_exp(input int d, input int l, input int f, input int n);
    int k = 0;
    for (int i = 0; i < n; i++) begin
      int p = int'(pix_mem[i]) & mk(d);
      case (f)
        0: begin exp_mem[k] = p & mk(l); k++; end
        1: begin exp_mem[k] = (p >> l) & mk(l); exp_mem[k+1] = p & mk(l); k += 2; end
        2: begin
          exp_mem[k] = (p >> (2*l)) & mk(l); exp_mem[k+1] = (p >> l) & mk(l);
          exp_mem[k+2] = p & mk(l); k += 3;
        end
        default: begin
          if (i % 2 == 1) begin
            int a = int'(pix_mem[i-1]) & mk(d);
            int h = l / 2;
            exp_mem[k]   = a >> (d - l);
            exp_mem[k+1] = ((a & mk(h)) << h) | (p >> (d - h));
            exp_mem[k+2] = p & mk(l);
            k += 3;
          end
        end
      endcase
    end
    return k;
  endfunction

  task automatic run_frame(input int dc, input int lc, input int fc, input int n,
                           input bit stall, input bit mid, input string req);
    int nexp, ngot, pi, cyc, overlap;
    bit done;
    for (int i = 0; i < n; i++)
      pix_mem[i] = 24'hA5C3F1 ^ (24'(i) * 24'h13579B) ^ (24'(dc) << 20);
    nexp = build_exp(dtab[dc], ltab[lc], fc, n);
    @(negedge clk);
    depth_i = 2'(dc); lines_i = 2'(lc); fmt_i = 2'(fc);
    pix_total_i = CNT_W'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R1: accepted start
    check(busy_o == 1'b1 && cfg_err_o == 1'b0, {req, "/R1 start accepted"},
          {busy_o, cfg_err_o}, 2);
    ngot = 0; pi = 0; cyc = 0; overlap = 0; done = 1'b0;
    while (!done && cyc < 400) begin
      pix_valid_i = (pi < n);
      pix_data_i  = pix_mem[pi % 16];
      bus_ready_i = !(stall && (cyc % 3 == 1));
      start_i     = mid && (cyc == 2);
      if (mid) begin depth_i = 2'd3; lines_i = 2'd2; fmt_i = 2'd0; pix_total_i = 5; end
      #1;
      if (pix_ready_o && bus_valid_o) overlap++;
      if (pix_valid_i && pix_ready_o) pi++;
      if (bus_valid_o && bus_ready_i && ngot < 64) begin
        got_mem[ngot] = int'(bus_data_o); ngot++;
      end
      @(negedge clk);
      cyc++;
      if (frame_done_o) done = 1'b1;
    end
    start_i = 1'b0; pix_valid_i = 1'b0; bus_ready_i = 1'b0;
    check(done, {req, "/R8 frame done seen"}, int'(done), 1);
    check(overlap == 0, {req, "/R7 ready while word pending"}, overlap, 0);
    check(busy_o == 1'b0, {req, "/R8 busy cleared"}, int'(busy_o), 0);
    check(pi == n, {req, "/R8 pixels taken"}, pi, n);
    check(ngot == nexp, {req, " word count"}, ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      check(got_mem[i] == exp_mem[i], {req, " word value"}, got_mem[i], exp_mem[i]);
    if (mid) check(cfg_err_o == 1'b0, "R9 error flag untouched", int'(cfg_err_o), 0);
    #1;
    check(pix_ready_o == 1'b0, {req, "/R8 no pixel after end"}, int'(pix_ready_o), 0);
    @(negedge clk);
    check(frame_done_o == 1'b0, {req, "/R8 done is one cycle"}, int'(frame_done_o), 0);
  endtask

  task automatic run_bad(input int dc, input int lc, input int fc, input int n,
                         input string what);
    @(negedge clk);
    depth_i = 2'(dc); lines_i = 2'(lc); fmt_i = 2'(fc);
    pix_total_i = CNT_W'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; pix_valid_i = 1'b1; bus_ready_i = 1'b1;
    #1;
    // R2
    check(cfg_err_o == 1'b1 && busy_o == 1'b0, {"R2 refused ", what},
          {cfg_err_o, busy_o}, 2);
    check(pix_ready_o == 1'b0, {"R2 no pixel taken ", what}, int'(pix_ready_o), 0);
    repeat (3) @(negedge clk);
    check(bus_valid_o == 1'b0 && busy_o == 1'b0, {"R2 stays idle ", what},
          {bus_valid_o, busy_o}, 0);
    pix_valid_i = 1'b0; bus_ready_i = 1'b0;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R10 reset state
    check({busy_o, cfg_err_o, frame_done_o, bus_valid_o, pix_ready_o} == 5'b0,
          "R10 reset state", {busy_o, cfg_err_o, frame_done_o, bus_valid_o, pix_ready_o}, 0);

    run_frame(1, 3, 0, 4, 1'b0, 1'b0, "R3 16 on 16");
    run_frame(0, 2, 0, 3, 1'b0, 1'b0, "R3 12 on 12");
    run_frame(1, 0, 1, 3, 1'b0, 1'b0, "R4 16 on 8");
    run_frame(2, 1, 1, 3, 1'b0, 1'b0, "R4 18 on 9");
    run_frame(3, 2, 1, 2, 1'b0, 1'b0, "R4 24 on 12");
    run_frame(3, 0, 2, 3, 1'b0, 1'b0, "R5 24 on 8");
    run_frame(0, 0, 3, 4, 1'b0, 1'b0, "R6 12 on 8");
    run_frame(2, 2, 3, 6, 1'b0, 1'b0, "R6 18 on 12");
    run_frame(3, 3, 3, 4, 1'b1, 1'b0, "R6/R7 24 on 16 stalled");

    run_bad(1, 2, 1, 4, "16 on 12");
    run_bad(1, 0, 0, 4, "wrong format");
    run_frame(1, 0, 1, 2, 1'b0, 1'b0, "R2 clears error");
    run_bad(3, 3, 3, 3, "odd pair count");
    run_bad(0, 2, 0, 0, "zero count");

    run_frame(1, 0, 1, 3, 1'b0, 1'b1, "R9 start while busy");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule